// File: doc/BRIEF.md
# Tuner Configuration Two-Wire Slave

This block is a two-wire (I2C-compatible) slave that gives a bus master access to the configuration of a tuner. It watches oversampled SCL and SDA lines in the system clock domain and pulls SDA low through an open-drain enable. It keeps twelve writable 8-bit configuration registers. A read returns two status bytes that are built from external status inputs and an internal power-on flag.

A write transfer carries a register index and then one or more data bytes. The index advances after each data byte and stops at the last register. Each accepted data byte is also issued on a one-cycle write strobe that carries the register index, so that downstream logic can react to it. A read transfer has no index phase. It always returns the first status byte and then the second. The power-on flag is sticky and is cleared only by a read transfer that is closed with STOP. The strobe cannot be stalled, because the bus offers no back-pressure and this slave never stretches the clock. It therefore has a valid signal and no ready signal, and its consumer must accept every beat. The system clock must run at least 16 times faster than SCL.

Top module: `i2c_tuner_regs`

## Requirements
- R1: After reset SDA is released and the twelve registers hold, for indices 0 to 11: 0x80, 0x23, 0x02, 0xF6, 0x84, 0x01, 0x80, 0xCC, 0x4B, 0x00, 0x00, 0x00. Register k appears on cfg_o[8k+7:8k]. The power-on flag (status byte one, bit 7) is 1 after reset.
- R2: The slave address is 110000 followed by the strap bit. A START followed by that address acknowledges on the ninth clock. Any other address is not acknowledged, and the slave ignores the rest of that transfer.
- R3: With R/W = 0, the first byte after the address sets the register index. Each following byte is written to the current index and then the index increments. Every accepted data byte is acknowledged and gives exactly one wr_valid_o cycle carrying wr_idx_o and wr_data_o. The register changes only with that strobe.
- R4: Bytes travel most significant bit first. Sending 0x01 stores 0x01, not 0x80.
- R5: The index stops at 11, so further data bytes rewrite register 11. Data bytes sent with an index above 11 are acknowledged and discarded, and no strobe is issued for them.
- R6: With R/W = 1, the slave sends {power-on flag, stat1_i[6:0]} and then stat2_i, most significant bit first, with no index phase. It drives SDA low only for 0 bits.
- R7: The power-on flag stays set through write transfers. It clears only after a read transfer that ends with STOP.
- R8: After the master NACKs a read byte, the slave leaves SDA released until the next START.
- R9: The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap_i | input | 1 | Selects the least significant bit of the bus address |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| stat1_i | input | 7 | Lower seven bits of status byte one |
| stat2_i | input | 8 | Status byte two |
| cfg_o | output | 96 | The twelve configuration registers, register k at bits 8k+7:8k |
| wr_valid_o | output | 1 | One-cycle strobe for an accepted data byte (no ready) |
| wr_idx_o | output | 4 | Register index for the strobe |
| wr_data_o | output | 8 | Data byte for the strobe |

## Verification
A wrong bit counter or phase shows up on the bus within a single byte. The acknowledge moves, vanishes or appears where it should not, and read data comes out shifted. An index that is corrupted or fails to saturate changes cfg_o within a few system clocks after the eighth data bit, and the per-clock register comparison catches it there. A power-on flag that is cleared at the wrong time is not visible until the next status read, so the bench reads the status after write-only traffic and again after a completed read.

// File: rtl/i2c_tuner_pkg.sv
package i2c_tuner_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK_SETUP, PH_ACK_OUT, PH_TX, PH_ACK_IN, PH_WAIT
  } phase_t;

  typedef enum logic [1:0] {K_ADDR, K_INDEX, K_DATA} kind_t;

  function automatic logic [BYTE_W-1:0] cfg_default(input int idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h23;
      2:       return 8'h02;
      3:       return 8'hF6;
      4:       return 8'h84;
      5:       return 8'h01;
      6:       return 8'h80;
      7:       return 8'hCC;
      8:       return 8'h4B;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] chain [STAGES];
  logic [1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 2'b11;
    else        chain[0] <= {scl_i, sda_i};
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= 2'b11;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= chain[STAGES-1];
  end

  logic scl_now, sda_now, scl_old, sda_old;
  assign scl_now = chain[STAGES-1][1];
  assign sda_now = chain[STAGES-1][0];
  assign scl_old = prev_q[1];
  assign sda_old = prev_q[0];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_tuner_pkg::*;
#(
  parameter int          NUM_CFG = 12,
  parameter logic [5:0]  ADDR_HI = 6'b110000,
  localparam int         IDX_W   = $clog2(NUM_CFG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_strap,
  input  logic              por_flag,
  input  logic [6:0]        stat1,
  input  logic [7:0]        stat2,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [7:0]        wr_data,
  output logic              por_clr,
  output logic              rd_seen
);
  localparam logic [7:0] LAST_IDX = 8'(NUM_CFG - 1);

  phase_t     phase;
  kind_t      kind;
  logic [2:0] bitcnt;
  logic [7:0] shreg, txbuf, ptr;
  logic       rw, tx_second, master_ack;
  logic [7:0] byte_in;
  logic [6:0] my_addr;

  assign byte_in = {shreg[6:0], sda_s};
  assign my_addr = {ADDR_HI, addr_strap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; kind <= K_ADDR; bitcnt <= '0;
      shreg <= '0; txbuf <= '0; ptr <= '0;
      rw <= 1'b0; tx_second <= 1'b0; master_ack <= 1'b0;
      wr_valid <= 1'b0; wr_idx <= '0; wr_data <= '0;
      por_clr <= 1'b0; rd_seen <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      por_clr  <= 1'b0;
      if (start_det) begin
        phase  <= PH_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        por_clr <= rd_seen;
        rd_seen <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: if (scl_rise) begin
            shreg  <= byte_in;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              unique case (kind)
                K_ADDR: begin
                  if (byte_in[7:1] == my_addr) begin
                    rw    <= byte_in[0];
                    phase <= PH_ACK_SETUP;
                  end else begin
                    phase <= PH_WAIT;
                  end
                end
                K_INDEX: begin
                  ptr   <= byte_in;
                  kind  <= K_DATA;
                  phase <= PH_ACK_SETUP;
                end
                default: begin
                  if (ptr <= LAST_IDX) begin
                    wr_valid <= 1'b1;
                    wr_idx   <= ptr[IDX_W-1:0];
                    wr_data  <= byte_in;
                  end
                  if (ptr < LAST_IDX) ptr <= ptr + 8'd1;
                  phase <= PH_ACK_SETUP;
                end
              endcase
            end
          end
          PH_ACK_SETUP: if (scl_fall) phase <= PH_ACK_OUT;
          PH_ACK_OUT: if (scl_fall) begin
            bitcnt <= '0;
            if (kind == K_ADDR && rw) begin
              phase     <= PH_TX;
              txbuf     <= {por_flag, stat1};
              tx_second <= 1'b0;
            end else begin
              if (kind == K_ADDR) kind <= K_INDEX;
              phase <= PH_RX;
            end
          end
          PH_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              phase  <= PH_ACK_IN;
              bitcnt <= '0;
            end else begin
              txbuf  <= {txbuf[6:0], 1'b1};
              bitcnt <= bitcnt + 3'd1;
            end
          end
          PH_ACK_IN: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
              if (!tx_second) rd_seen <= 1'b1;
            end
            if (scl_fall) begin
              if (master_ack && !tx_second) begin
                txbuf     <= stat2;
                tx_second <= 1'b1;
                phase     <= PH_TX;
              end else begin
                phase <= PH_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = (phase == PH_ACK_OUT) || (phase == PH_TX && !txbuf[7]);
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
  import i2c_tuner_pkg::*;
#(
  parameter  int NUM_CFG = 12,
  localparam int IDX_W   = $clog2(NUM_CFG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [7:0]               wr_data,
  input  logic                     por_clr,
  output logic                     por_flag,
  output logic [NUM_CFG*8-1:0]     cfg
);
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    q <= cfg_default(g);
      else if (wr_valid && wr_idx == IDX_W'(g))      q <= wr_data;
    end
    assign cfg[g*8 +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       por_flag <= 1'b1;
    else if (por_clr) por_flag <= 1'b0;
  end
endmodule

// File: rtl/i2c_tuner_regs.sv
module i2c_tuner_regs #(
  parameter  int         NUM_CFG     = 12,
  parameter  int         SYNC_STAGES = 2,
  parameter  logic [5:0] ADDR_HI     = 6'b110000,
  localparam int         IDX_W       = $clog2(NUM_CFG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_strap_i,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [6:0]           stat1_i,
  input  logic [7:0]           stat2_i,
  output logic [NUM_CFG*8-1:0] cfg_o,
  output logic                 wr_valid_o,
  output logic [IDX_W-1:0]     wr_idx_o,
  output logic [7:0]           wr_data_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic por_flag, por_clr, rd_seen;

  i2c_bus_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.NUM_CFG(NUM_CFG), .ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_strap(addr_strap_i), .por_flag(por_flag), .stat1(stat1_i),
    .stat2(stat2_i), .sda_oe(sda_oe_o), .wr_valid(wr_valid_o),
    .wr_idx(wr_idx_o), .wr_data(wr_data_o), .por_clr(por_clr),
    .rd_seen(rd_seen)
  );

  i2c_cfg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid_o), .wr_idx(wr_idx_o),
    .wr_data(wr_data_o), .por_clr(por_clr), .por_flag(por_flag),
    .cfg(cfg_o)
  );
endmodule

// File: rtl/i2c_tuner_regs_chk.sv
module i2c_tuner_regs_chk #(
  parameter  int NUM_CFG = 12,
  localparam int IDX_W   = $clog2(NUM_CFG)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_i,
  input logic                 sda_oe_o,
  input logic                 wr_valid_o,
  input logic [IDX_W-1:0]     wr_idx_o,
  input logic [7:0]           wr_data_o,
  input logic [NUM_CFG*8-1:0] cfg_o,
  input logic                 por_flag,
  input logic                 rd_seen
);
  logic [IDX_W-1:0] last_idx;
  logic [7:0]       last_data;
  always_ff @(posedge clk) begin
    last_idx  <= wr_idx_o;
    last_data <= wr_data_o;
  end

  assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  assert_strobe_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> cfg_o[int'(last_idx)*8 +: 8] == last_data);

  assert_no_silent_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_o |=> $stable(cfg_o));

  assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> int'(wr_idx_o) < NUM_CFG);

  assert_por_clear_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(rd_seen, 2));

  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_tuner_regs i2c_tuner_regs_chk #(.NUM_CFG(NUM_CFG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .wr_valid_o(wr_valid_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
  .cfg_o(cfg_o), .por_flag(por_flag), .rd_seen(rd_seen)
);

// File: tb/i2c_tuner_regs_tb_top.sv
module i2c_tuner_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int NREG = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] stat1 = 7'h35;
  logic [7:0] stat2 = 8'hA6;
  logic sda_oe, wr_valid;
  logic [3:0] wr_idx;
  logic [7:0] wr_data;
  logic [NREG*8-1:0] cfg;
  wire sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tuner_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strap_i(strap), .scl_i(scl_m),
    .sda_i(sda_bus), .sda_oe_o(sda_oe), .stat1_i(stat1), .stat2_i(stat2),
    .cfg_o(cfg), .wr_valid_o(wr_valid), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  bit hold = 1'b1, done = 1'b0;
  logic [7:0] exp_reg [NREG];
  int cur_idx = 0;
  logic [11:0] exp_q [$];
  logic [11:0] got_q [$];

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] exp_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = exp_reg[i];
    return f;
  endfunction

  task automatic model_reset();
    logic [7:0] d [NREG] = '{8'h80, 8'h23, 8'h02, 8'hF6, 8'h84, 8'h01,
                             8'h80, 8'hCC, 8'h4B, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < NREG; i++) exp_reg[i] = d[i];
  endtask

  // per-clock comparison of the register image against the model (R1, R3)
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !hold && !done) chk(cfg == exp_flat(), "R3 cfg image", cfg, exp_flat());
    if (rst_n && wr_valid) got_q.push_back({wr_idx, wr_data});
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit b, output bit s);
    sda_m = b; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    s = sda_bus; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) pulse(b[i], s);
    pulse(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      pulse(1'b1, s);
      b[i] = s;
    end
    pulse(!mack, s);
  endtask

  task automatic widx(input logic [7:0] b);
    bit ak;
    send_byte(b, ak);
    chk(ak, "R3 index ack", ak, 1);
    cur_idx = b;
  endtask

  task automatic wdata(input logic [7:0] b);
    bit ak;
    hold = 1'b1;
    send_byte(b, ak);
    chk(ak, "R5 data ack", ak, 1);
    if (cur_idx < NREG) begin
      exp_reg[cur_idx] = b;
      exp_q.push_back({4'(cur_idx), b});
    end
    if (cur_idx < NREG - 1) cur_idx++;
    hold = 1'b0;
  endtask

  task automatic check_strobes(input string req);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic do_reset();
    hold = 1'b1;
    rst_n = 1'b0;
    model_reset();
    cur_idx = 0;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    hold = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    waitc(100000);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cycles, 100000);
    finish_run();
  end

  initial begin
    bit ak, s;
    logic [7:0] b;
    do_reset();

    // R1: reset state
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(cfg == exp_flat(), "R1 defaults", cfg, exp_flat());

    // R2/R3/R4: write two bytes from index 0
    bus_start();
    send_byte(8'hC0, ak); chk(ak, "R2 address ack", ak, 1);
    widx(8'h00); wdata(8'h01); wdata(8'h80);
    bus_stop();
    chk(cfg[7:0] == 8'h01, "R4 msb first", cfg[7:0], 8'h01);
    chk(cfg[15:8] == 8'h80, "R3 auto increment", cfg[15:8], 8'h80);
    check_strobes("R3 strobes");

    // R2: foreign address ignored
    bus_start();
    send_byte(8'hC2, ak); chk(!ak, "R2 foreign nack", ak, 0);
    send_byte(8'h05, ak); send_byte(8'h55, ak);
    chk(!ak, "R2 ignored bytes", ak, 0);
    bus_stop();
    check_strobes("R2 no strobe");

    // R5: saturation at last index
    bus_start();
    send_byte(8'hC0, ak);
    widx(8'h0A); wdata(8'h11); wdata(8'h22); wdata(8'h33);
    bus_stop();
    chk(cfg[87:80] == 8'h11, "R5 reg10", cfg[87:80], 8'h11);
    chk(cfg[95:88] == 8'h33, "R5 reg11 saturate", cfg[95:88], 8'h33);
    check_strobes("R5 strobes");

    // R5: out-of-range index discarded
    bus_start(); send_byte(8'hC0, ak); widx(8'h0C); wdata(8'h99); bus_stop();
    bus_start(); send_byte(8'hC0, ak); widx(8'h30); wdata(8'h77); wdata(8'h78); bus_stop();
    check_strobes("R5 discard");

    // R2: strap selects the alternative address
    strap = 1'b1;
    bus_start(); send_byte(8'hC0, ak); chk(!ak, "R2 strap nack", ak, 0); bus_stop();
    bus_start(); send_byte(8'hC2, ak); chk(ak, "R2 strap ack", ak, 1);
    widx(8'h09); wdata(8'h5A); bus_stop();
    check_strobes("R2 strap write");
    strap = 1'b0;

    // R6/R7: status read, flag still set after writes
    bus_start();
    send_byte(8'hC1, ak); chk(ak, "R6 read ack", ak, 1);
    recv_byte(1'b1, b); chk(b == 8'hB5, "R6 status one", b, 8'hB5);
    chk(b[7] == 1'b1, "R7 flag held over writes", b[7], 1);
    recv_byte(1'b0, b); chk(b == 8'hA6, "R6 status two", b, 8'hA6);
    bus_stop();

    // R7/R8: flag cleared; slave silent after NACK
    stat1 = 7'h0A;
    bus_start();
    send_byte(8'hC1, ak);
    recv_byte(1'b0, b); chk(b == 8'h0A, "R7 flag cleared", b, 8'h0A);
    for (int i = 0; i < 9; i++) begin
      pulse(1'b1, s);
      chk(s == 1'b1, "R8 released after nack", s, 1);
    end
    bus_stop();
    check_strobes("R6 read no strobe");

    // R1: reset restores defaults and the flag
    do_reset();
    chk(cfg == exp_flat(), "R1 defaults again", cfg, exp_flat());
    bus_start(); send_byte(8'hC1, ak);
    recv_byte(1'b0, b); chk(b[7] == 1'b1, "R1 flag after reset", b[7], 1);
    bus_stop();

    finish_run();
  end
endmodule